// File: doc/BRIEF.md
# I2C Bus Recovery Clock Sequencer

A reset of the I2C master in the middle of a transfer can leave the bus stuck. If a target was driving a 0 data bit at that moment, it keeps SDA low while SCL floats high. The normal I2C controller reads a low SDA as a sign that another master may own the bus, so it waits and never starts a transfer. This block clears that state. It must be run before the controller attempts its first transfer.

A one-cycle start request makes the block take the SCL pad away from the controller. It then clocks SCL in open-drain fashion through a fixed train of pulses. In each pulse SCL is pulled low for one phase and then released for one phase. The phase length is at least 3 µs, counted in system clock cycles. After the last released phase, SCL goes back to the controller. A done pulse marks the hand-back, and a status flag reports whether SDA was still low at the end. The block never drives SDA.

Top module: `bus_unstick`

## Requirements
- R1: While reset is asserted and after it is released, busy_o, done_o, stuck_o, route_rec_o and the sequencer's own pull are 0, so pad_scl_pull_o equals ctrl_scl_pull_i.
- R2: A start_i sampled high while busy_o is 0 sets busy_o and route_rec_o to 1 on the next cycle, and starts a low phase at once (pad_scl_pull_o = 1, where 1 means SCL is pulled low).
- R3: While route_rec_o is 0, pad_scl_pull_o follows ctrl_scl_pull_i. While it is 1, ctrl_scl_pull_i has no effect on pad_scl_pull_o.
- R4: Each low phase and each released phase lasts exactly PHASE_CYC cycles. A burst alternates low then released, starting with low.
- R5: A burst contains exactly PULSES low phases (default 16).
- R6: busy_o stays 1 for exactly 2*PULSES*PHASE_CYC cycles per burst. route_rec_o equals busy_o in every cycle.
- R7: done_o is 1 for exactly one cycle: the first cycle with route_rec_o back at 0 after a burst.
- R8: A start_i that arrives while busy_o is 1, including the final cycle of a burst, is ignored. It neither lengthens nor restarts the burst.
- R9: stuck_o takes the inverse of sda_i sampled in the last cycle of the final released phase. It is valid from the done cycle and holds until the next burst ends.
- R10: PHASE_CYC is the ceiling of CLK_HZ*PHASE_NS/1e9, with a minimum of 1. At 100 MHz and 3000 ns this gives 300.
- R11: The sequencer pulls SCL only while busy_o is 1. Outside a burst it leaves SCL released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to run one recovery burst |
| sda_i | input | 1 | Sensed SDA level, already synchronised |
| ctrl_scl_pull_i | input | 1 | Controller's SCL pull-low enable |
| pad_scl_pull_o | output | 1 | Open-drain pull-low enable to the SCL pad (1 = drive low, 0 = release) |
| route_rec_o | output | 1 | Pin select: 1 = sequencer owns SCL, 0 = controller owns SCL |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | One-cycle pulse when SCL is handed back |
| stuck_o | output | 1 | SDA was still low at the end of the last burst |

## Verification
A start sampled at edge 1 shows busy_o, route_rec_o and the first low phase after that edge. The pull in bench cycle k of a burst (k = 1..2*PULSES*PHASE_CYC) is therefore due as low when (k-1)/PHASE_CYC is even. done_o, the cleared select and stuck_o are due one cycle after the last burst cycle, and done_o must drop one cycle after that. The bench drives every input on the falling edge and reads every output just before it redrives. Each expected value is tied to a known cycle index within the burst, and the start, SDA and controller pull inputs are randomised on every cycle.

// File: rtl/bus_unstick_pkg.sv
package bus_unstick_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  // Cycles per phase: ceiling of hz*ns/1e9, never below one.
  function automatic int unsigned phase_cycles(longint unsigned hz, longint unsigned ns);
    longint unsigned q;
    q = (hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
    if (q == 0) q = 1;
    return int'(q);
  endfunction

  // Counter width able to hold values 0..n-1.
  function automatic int unsigned idx_width(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/bus_unstick_timer.sv
module bus_unstick_timer #(
  parameter int unsigned PHASE_CYC = 300,
  localparam int unsigned TW = bus_unstick_pkg::idx_width(PHASE_CYC)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic phase_end_o
);

  localparam logic [TW-1:0] LAST = TW'(PHASE_CYC - 1);

  logic [TW-1:0] cnt_q;
  logic          at_last;

  assign at_last     = (cnt_q == LAST);
  assign phase_end_o = run_i && at_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!run_i || at_last) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/bus_unstick_fsm.sv
module bus_unstick_fsm #(
  parameter int unsigned PULSES = 16,
  localparam int unsigned NW = bus_unstick_pkg::idx_width(PULSES)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic phase_end_i,
  output logic accept_o,
  output logic busy_o,
  output logic seq_pull_o,
  output logic burst_end_o
);
  import bus_unstick_pkg::*;

  localparam logic [NW-1:0] LAST_PULSE = NW'(PULSES - 1);

  phase_e        ph_q;
  logic [NW-1:0] pulse_q;
  logic          last_pulse;

  assign last_pulse  = (pulse_q == LAST_PULSE);
  assign accept_o    = (ph_q == PH_IDLE) && start_i;
  assign busy_o      = (ph_q != PH_IDLE);
  assign seq_pull_o  = (ph_q == PH_LOW);
  assign burst_end_o = (ph_q == PH_HIGH) && phase_end_i && last_pulse;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= PH_IDLE;
      pulse_q <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: begin
          if (start_i) begin
            ph_q    <= PH_LOW;
            pulse_q <= '0;
          end
        end
        PH_LOW: begin
          if (phase_end_i) ph_q <= PH_HIGH;
        end
        PH_HIGH: begin
          if (phase_end_i) begin
            if (last_pulse) begin
              ph_q <= PH_IDLE;
            end else begin
              ph_q    <= PH_LOW;
              pulse_q <= pulse_q + 1'b1;
            end
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bus_unstick_route.sv
module bus_unstick_route (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic accept_i,
  input  logic burst_end_i,
  input  logic seq_pull_i,
  input  logic ctrl_pull_i,
  input  logic sda_i,
  output logic sel_o,
  output logic pad_pull_o,
  output logic done_o,
  output logic stuck_o
);

  assign pad_pull_o = sel_o ? seq_pull_i : ctrl_pull_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_o   <= 1'b0;
      done_o  <= 1'b0;
      stuck_o <= 1'b0;
    end else begin
      done_o <= burst_end_i;
      if (accept_i) begin
        sel_o <= 1'b1;
      end else if (burst_end_i) begin
        sel_o <= 1'b0;
      end
      if (burst_end_i) stuck_o <= !sda_i;
    end
  end

endmodule

// File: rtl/bus_unstick.sv
module bus_unstick #(
  parameter longint unsigned CLK_HZ   = 100_000_000,
  parameter longint unsigned PHASE_NS = 3000,
  parameter int unsigned     PULSES   = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic sda_i,
  input  logic ctrl_scl_pull_i,
  output logic pad_scl_pull_o,
  output logic route_rec_o,
  output logic busy_o,
  output logic done_o,
  output logic stuck_o
);

  localparam int unsigned PHASE_CYC = bus_unstick_pkg::phase_cycles(CLK_HZ, PHASE_NS);

  // Named internal events, also observed by the bound checker.
  logic accept;
  logic phase_end;
  logic burst_end;
  logic seq_pull;

  bus_unstick_timer #(.PHASE_CYC(PHASE_CYC)) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (busy_o),
    .phase_end_o (phase_end)
  );

  bus_unstick_fsm #(.PULSES(PULSES)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .phase_end_i (phase_end),
    .accept_o    (accept),
    .busy_o      (busy_o),
    .seq_pull_o  (seq_pull),
    .burst_end_o (burst_end)
  );

  bus_unstick_route u_route (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .burst_end_i (burst_end),
    .seq_pull_i  (seq_pull),
    .ctrl_pull_i (ctrl_scl_pull_i),
    .sda_i       (sda_i),
    .sel_o       (route_rec_o),
    .pad_pull_o  (pad_scl_pull_o),
    .done_o      (done_o),
    .stuck_o     (stuck_o)
  );

endmodule

// File: rtl/bus_unstick_chk.sv
module bus_unstick_chk #(
  parameter int unsigned PHASE_CYC = 300,
  parameter int unsigned PULSES    = 16
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic sda_i,
  input logic ctrl_scl_pull_i,
  input logic pad_scl_pull_o,
  input logic route_rec_o,
  input logic busy_o,
  input logic done_o,
  input logic stuck_o,
  input logic seq_pull,
  input logic burst_end
);

  int unsigned low_run, high_run, rise_cnt;
  logic        prev_pull;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_run   <= 0;
      high_run  <= 0;
      rise_cnt  <= 0;
      prev_pull <= 1'b0;
    end else begin
      prev_pull <= seq_pull;
      low_run   <= seq_pull ? low_run + 1 : 0;
      high_run  <= (busy_o && !seq_pull) ? high_run + 1 : 0;
      if (start_i && !busy_o) rise_cnt <= 0;
      else if (seq_pull && !prev_pull) rise_cnt <= rise_cnt + 1;
    end
  end

  // R2
  start_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && route_rec_o && pad_scl_pull_o));

  // R3
  ctrl_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !route_rec_o |-> (pad_scl_pull_o == ctrl_scl_pull_i));

  // R4
  low_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(seq_pull) |-> (low_run == PHASE_CYC));

  // R4
  high_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $rose(seq_pull) && high_run != 0) |-> (high_run == PHASE_CYC));

  // R4
  last_high_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (high_run == PHASE_CYC));

  // R5
  pulse_total_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (rise_cnt == PULSES));

  // R6
  busy_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o == route_rec_o);

  // R7
  done_handback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!route_rec_o && $past(route_rec_o)));

  // R7
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy_o && !burst_end) |=> busy_o);

  // R9
  stuck_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (stuck_o == !$past(sda_i)));

  // R11
  idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !seq_pull);

endmodule

bind bus_unstick bus_unstick_chk #(.PHASE_CYC(PHASE_CYC), .PULSES(PULSES)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .start_i         (start_i),
  .sda_i           (sda_i),
  .ctrl_scl_pull_i (ctrl_scl_pull_i),
  .pad_scl_pull_o  (pad_scl_pull_o),
  .route_rec_o     (route_rec_o),
  .busy_o          (busy_o),
  .done_o          (done_o),
  .stuck_o         (stuck_o),
  .seq_pull        (seq_pull),
  .burst_end       (burst_end)
);

// File: tb/tb_bus_unstick.sv
`timescale 1ns/1ps
module tb_bus_unstick;

  localparam int NPULSE = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic sda = 1'b1;
  logic ctrl = 1'b0;
  logic pad, sel, busy, done, stuck;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  bus_unstick dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .sda_i(sda),
    .ctrl_scl_pull_i(ctrl), .pad_scl_pull_o(pad), .route_rec_o(sel),
    .busy_o(busy), .done_o(done), .stuck_o(stuck)
  );

  // R10: smallest cycle count whose duration covers the phase time.
  function automatic int exp_phase(longint hz, longint ns);
    int n = 1;
    while (longint'(n) * 64'd1_000_000_000 < hz * ns) n++;
    return n;
  endfunction

  localparam int P = exp_phase(100_000_000, 3000);
  localparam int T = 2 * NPULSE * P;

  // Expected pull in burst cycle k (1-based): low phases are even-indexed.
  function automatic bit exp_pull(int k);
    return (((k - 1) / P) % 2) == 0;
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // mode: 0 plain, 1 start on final cycle, 2 final sda low,
  // 3 final sda high, 4 restart on done cycle. pre: start already driven.
  task automatic run_burst(bit pre, int mode);
    int bad_busy = 0, bad_pull = 0, bad_done = 0, rises = 0, busy_len = 0;
    bit last_sda = 1'b1, prev_pad = 1'b0, first_ok = 1'b0;
    if (!pre) begin
      @(negedge clk);
      start = 1'b1;
    end
    for (int k = 1; k <= T; k++) begin
      @(negedge clk);
      if (k == 1) first_ok = busy && sel && pad;
      if (busy) busy_len++;
      if (!busy || !sel) bad_busy++;
      if (pad != exp_pull(k)) bad_pull++;
      if (done) bad_done++;
      if (pad && !prev_pad) rises++;
      prev_pad = pad;
      start = (mode == 1 && k == T) ? 1'b1 : (($urandom % 64) == 0);
      ctrl  = 1'($urandom);
      if (k == T) begin
        sda = (mode == 2) ? 1'b0 : (mode == 3) ? 1'b1 : 1'($urandom);
        last_sda = sda;
      end else begin
        sda = 1'($urandom);
      end
    end
    @(negedge clk);
    chk(first_ok, "R2 busy/select/low on first cycle", int'(first_ok), 1);
    chk(bad_pull == 0, "R3 R4 pull shape with random ctrl", bad_pull, 0);
    chk(rises == NPULSE, "R5 low phase count", rises, NPULSE);
    chk(bad_busy == 0 && !busy && !sel, "R6 R8 busy length", busy_len, T);
    chk(done && bad_done == 0, "R7 done on hand-back", int'(done), 1);
    chk(stuck == !last_sda, "R9 stuck flag", int'(stuck), int'(!last_sda));
    chk(pad == ctrl, "R3 pad back to controller", int'(pad), int'(ctrl));
    start = (mode == 4);
    sda   = 1'($urandom);
    if (mode != 4) begin
      @(negedge clk);
      chk(!done, "R7 done single cycle", int'(done), 0);
      chk(!busy, "R8 late start ignored", int'(busy), 0);
      chk(stuck == !last_sda, "R9 stuck held", int'(stuck), int'(!last_sda));
      start = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int bad_idle;
    void'($urandom(32'd20240611));
    ctrl = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !sel && !done && !stuck, "R1 state in reset", int'({busy, sel, done, stuck}), 0);
    chk(pad == 1'b1, "R1 pad follows ctrl in reset", int'(pad), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !sel && !done && !stuck, "R1 state after reset", int'({busy, sel, done, stuck}), 0);

    bad_idle = 0;
    for (int i = 0; i < 40; i++) begin
      ctrl = 1'($urandom);
      sda  = 1'($urandom);
      #1;
      if (pad != ctrl || sel || busy) bad_idle++;
      @(negedge clk);
    end
    chk(bad_idle == 0, "R3 R11 idle pass-through", bad_idle, 0);
    chk(P == 300, "R10 phase cycles at 100 MHz", P, 300);

    run_burst(1'b0, 0);
    run_burst(1'b0, 2);
    run_burst(1'b0, 1);
    run_burst(1'b0, 4);
    run_burst(1'b1, 3);
    repeat (5) @(negedge clk);
    run_burst(1'b0, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule